// File: doc/BRIEF.md
# CPU-to-PCI Address Window Decoder

This block holds the decode registers for six CPU-to-PCI address windows: an I/O window and two memory windows for each of two PCI ports. Software programs each window through a word-addressed 32-bit register bus. Each window has three registers. The low register sets the base of the window, the high register sets the end of its range, and the remap register sets where CPU accesses land on the PCI side. The window granularity is 2 MB. The block reports, for every window, whether it is valid, its first 2 MB unit and its length in 2 MB units.

Alongside the register file, a combinational path compares a CPU physical address against all valid windows. It reports a hit and the index of the window that matched, and it produces the translated PCI address. The top address bits are replaced by the remap base, and the byte offset inside the window is kept.

A write to a low register has a side effect: it also loads the paired remap register. Software that wants a translation other than the identity must therefore write the remap register after the low register.

Top module: `pciwin_decoder`

## Requirements
- R1: Address bits 11:2 select a 32-bit word. Window i uses word 4i for its low register, word 4i+1 for its high register and word 4i+2 for its remap register. Every other word reads as zero, and writes to it change nothing.
- R2: A write to a low register keeps bits 14:0 of the data. The same write loads bits 10:0 of the data into that window's remap register.
- R3: A direct write to a high register keeps bits 6:0 of the data. A direct write to a remap register keeps bits 10:0 of the data.
- R4: A window is valid exactly when bits 6:0 of its low register are less than or equal to its high register. The equal case gives a valid window one unit long.
- R5: The start unit of a window is low[10:0], so the byte start is low shifted left by 21 within a 32-bit CPU space. The length in 2 MB units is high + 1 − low[6:0] when the window is valid, and 0 when it is not.
- R6: After reset, the windows hold these values, in index order. Window 0 (I/O, port 0): low 0x080, high 0x0F. Window 1 (memory 0, port 0): low 0x090, high 0x1F. Window 2 (memory 1, port 0): low 0x790, high 0x1F. Window 3 (I/O, port 1): low 0x100, high 0x0F. Window 4 (memory 0, port 1): low 0x110, high 0x1F. Window 5 (memory 1, port 1): low 0x120, high 0x2F. Each remap register equals its low register. The read data is zero.
- R7: In the same cycle, hit is 1 when cpu_addr[31:21] is at or above the start unit and below start plus length of some valid window. When windows overlap, hit_idx gives the lowest-numbered matching window.
- R8: On a hit, pci_addr[31:21] = (remap + cpu_addr[31:21] − start) mod 2^11, and pci_addr[20:0] = cpu_addr[20:0]. On a miss, pci_addr is zero.
- R9: A read presented with rd_en at one clock edge shows its zero-extended register value on rdata after that edge. rdata holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cpu_addr | input | 32 | CPU physical address to test |
| hit | output | 1 | cpu_addr falls in a valid window |
| hit_idx | output | 3 | Index of the matching window |
| pci_addr | output | 32 | Translated PCI address, or zero on a miss |
| win_valid | output | 6 | Per-window valid flags |
| win_start | output | 66 | Start units, 11 bits per window, window 0 in the low bits |
| win_len | output | 48 | Lengths in 2 MB units, 8 bits per window, window 0 in the low bits |

## Verification
A table of CPU addresses is run against the reset layout. For each window the table probes the first unit, the last unit and the unit just past the end, and it also probes gaps between windows. These probes tell an inclusive end compare from an exclusive one and show which window index is reported. A remapped window is then probed with offsets that wrap past 2^11 units, which separates modular translation from plain replacement of the top bits.

Directed writes follow. They use all-ones data to expose the field masks, and they set high equal to and one below low[6:0] to find the validity boundary. One test makes two windows overlap and then invalidates the lower one, which shows the priority order. Register readback covers the paired remap load on a low write and the words that are not mapped to any register.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

   // Register slot selected by the low two bits of the word index
   typedef enum logic [1:0] {
      SLOT_LOW   = 2'd0,
      SLOT_HIGH  = 2'd1,
      SLOT_REMAP = 2'd2,
      SLOT_NONE  = 2'd3
   } slot_e;

   localparam int WORDS_PER_WIN = 4;

   // Reset value of the low register of window idx
   function automatic logic [31:0] rst_low(input int idx);
      case (idx)
         0:       return 32'h080;
         1:       return 32'h090;
         2:       return 32'h790;
         3:       return 32'h100;
         4:       return 32'h110;
         5:       return 32'h120;
         default: return 32'h07F;   // extra windows come up invalid
      endcase
   endfunction

   // Reset value of the high register of window idx
   function automatic logic [31:0] rst_high(input int idx);
      case (idx)
         0:       return 32'h0F;
         1:       return 32'h1F;
         2:       return 32'h1F;
         3:       return 32'h0F;
         4:       return 32'h1F;
         5:       return 32'h2F;
         default: return 32'h00;
      endcase
   endfunction

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
   import pciwin_pkg::*;
#(
   parameter int NUM_WIN = 6,
   parameter int LOW_W   = 15,
   parameter int HIGH_W  = 7,
   parameter int REMAP_W = 11,
   parameter int REG_AW  = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [REG_AW-1:0]          addr,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   output logic [NUM_WIN*LOW_W-1:0]   low_q,
   output logic [NUM_WIN*HIGH_W-1:0]  high_q,
   output logic [NUM_WIN*REMAP_W-1:0] remap_q
);

   localparam int WORD_W = REG_AW - 2;
   localparam int SEL_W  = WORD_W - 2;

   logic [WORD_W-1:0] word;
   logic [SEL_W-1:0]  win_sel;
   slot_e             slot;
   logic              in_range;
   logic [31:0]       rd_val;

   assign word     = addr[REG_AW-1:2];
   assign win_sel  = word[WORD_W-1:2];
   assign slot     = slot_e'(word[1:0]);
   assign in_range = (int'(win_sel) < NUM_WIN);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [31:0]      RST_LO = rst_low(i);
      localparam logic [31:0]      RST_HI = rst_high(i);
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);

      logic [LOW_W-1:0]   low_r;
      logic [HIGH_W-1:0]  high_r;
      logic [REMAP_W-1:0] remap_r;
      logic               we;

      assign we = wr_en && in_range && (win_sel == MY_SEL);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            low_r   <= RST_LO[LOW_W-1:0];
            high_r  <= RST_HI[HIGH_W-1:0];
            remap_r <= RST_LO[REMAP_W-1:0];
         end else if (we) begin
            case (slot)
               SLOT_LOW: begin
                  low_r   <= wdata[LOW_W-1:0];
                  remap_r <= wdata[REMAP_W-1:0];
               end
               SLOT_HIGH:  high_r  <= wdata[HIGH_W-1:0];
               SLOT_REMAP: remap_r <= wdata[REMAP_W-1:0];
               default: ;
            endcase
         end
      end

      assign low_q[i*LOW_W +: LOW_W]       = low_r;
      assign high_q[i*HIGH_W +: HIGH_W]    = high_r;
      assign remap_q[i*REMAP_W +: REMAP_W] = remap_r;
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (in_range && int'(win_sel) == k) begin
            case (slot)
               SLOT_LOW:   rd_val = 32'(low_q[k*LOW_W +: LOW_W]);
               SLOT_HIGH:  rd_val = 32'(high_q[k*HIGH_W +: HIGH_W]);
               SLOT_REMAP: rd_val = 32'(remap_q[k*REMAP_W +: REMAP_W]);
               default:    rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

endmodule

// File: rtl/pciwin_calc.sv
module pciwin_calc #(
   parameter int NUM_WIN = 6,
   parameter int LOW_W   = 15,
   parameter int HIGH_W  = 7,
   parameter int UNIT_W  = 11,
   parameter int LEN_W   = 8
) (
   input  logic [NUM_WIN*LOW_W-1:0]  low_q,
   input  logic [NUM_WIN*HIGH_W-1:0] high_q,
   output logic [NUM_WIN-1:0]        win_valid,
   output logic [NUM_WIN*UNIT_W-1:0] win_start,
   output logic [NUM_WIN*LEN_W-1:0]  win_len
);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_calc
      logic [HIGH_W-1:0] lo_f;
      logic [HIGH_W-1:0] hi_f;
      logic              ok;

      assign lo_f = low_q[i*LOW_W +: HIGH_W];
      assign hi_f = high_q[i*HIGH_W +: HIGH_W];
      assign ok   = (lo_f <= hi_f);

      assign win_valid[i]                  = ok;
      assign win_start[i*UNIT_W +: UNIT_W] = low_q[i*LOW_W +: UNIT_W];
      assign win_len[i*LEN_W +: LEN_W]     = ok ? (LEN_W'(hi_f) + LEN_W'(1) - LEN_W'(lo_f))
                                                : '0;
   end

endmodule

// File: rtl/pciwin_match.sv
module pciwin_match #(
   parameter int NUM_WIN = 6,
   parameter int CPU_AW  = 32,
   parameter int GRAN_LG = 21,
   parameter int UNIT_W  = 11,
   parameter int LEN_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic [CPU_AW-1:0]         cpu_addr,
   input  logic [NUM_WIN-1:0]        win_valid,
   input  logic [NUM_WIN*UNIT_W-1:0] win_start,
   input  logic [NUM_WIN*LEN_W-1:0]  win_len,
   input  logic [NUM_WIN*UNIT_W-1:0] remap_q,
   output logic                      hit,
   output logic [IDX_W-1:0]          hit_idx,
   output logic [CPU_AW-1:0]         pci_addr
);

   logic [UNIT_W-1:0]  unit;
   logic [NUM_WIN-1:0] in_win;
   logic [UNIT_W-1:0]  sel_start;
   logic [UNIT_W-1:0]  sel_remap;
   logic [UNIT_W-1:0]  pci_unit;

   assign unit = cpu_addr[CPU_AW-1:GRAN_LG];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
      logic [UNIT_W:0] u_ext;
      logic [UNIT_W:0] s_ext;
      logic [UNIT_W:0] e_ext;

      assign u_ext     = {1'b0, unit};
      assign s_ext     = {1'b0, win_start[i*UNIT_W +: UNIT_W]};
      assign e_ext     = s_ext + (UNIT_W+1)'(win_len[i*LEN_W +: LEN_W]);
      assign in_win[i] = win_valid[i] && (u_ext >= s_ext) && (u_ext < e_ext);
   end

   // Scan from the top so the lowest matching index is written last
   always_comb begin
      hit       = 1'b0;
      hit_idx   = '0;
      sel_start = '0;
      sel_remap = '0;
      for (int k = NUM_WIN - 1; k >= 0; k--) begin
         if (in_win[k]) begin
            hit       = 1'b1;
            hit_idx   = IDX_W'(k);
            sel_start = win_start[k*UNIT_W +: UNIT_W];
            sel_remap = remap_q[k*UNIT_W +: UNIT_W];
         end
      end
   end

   assign pci_unit = sel_remap + (unit - sel_start);
   assign pci_addr = hit ? {pci_unit, cpu_addr[GRAN_LG-1:0]} : '0;

endmodule

// File: rtl/pciwin_decoder.sv
module pciwin_decoder #(
   parameter int NUM_WIN = 6,
   parameter int CPU_AW  = 32,
   parameter int GRAN_LG = 21,
   parameter int LOW_W   = 15,
   parameter int HIGH_W  = 7,
   parameter int REG_AW  = 12,
   localparam int UNIT_W = CPU_AW - GRAN_LG,
   localparam int LEN_W  = HIGH_W + 1,
   localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [REG_AW-1:0]         addr,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   input  logic [CPU_AW-1:0]         cpu_addr,
   output logic                      hit,
   output logic [IDX_W-1:0]          hit_idx,
   output logic [CPU_AW-1:0]         pci_addr,
   output logic [NUM_WIN-1:0]        win_valid,
   output logic [NUM_WIN*UNIT_W-1:0] win_start,
   output logic [NUM_WIN*LEN_W-1:0]  win_len
);

   if (NUM_WIN < 1 || NUM_WIN * pciwin_pkg::WORDS_PER_WIN > (1 << (REG_AW - 2))) begin : g_bad_win
      $error("NUM_WIN does not fit the register space");
   end
   if (CPU_AW > 32 || GRAN_LG >= CPU_AW) begin : g_bad_aw
      $error("CPU_AW/GRAN_LG out of range");
   end
   if (UNIT_W > LOW_W || HIGH_W > UNIT_W || LEN_W > UNIT_W + 1 || LOW_W > 32) begin : g_bad_fields
      $error("field widths inconsistent");
   end

   logic [NUM_WIN*LOW_W-1:0]  low_q;
   logic [NUM_WIN*HIGH_W-1:0] high_q;
   logic [NUM_WIN*UNIT_W-1:0] remap_q;

   pciwin_regs #(
      .NUM_WIN(NUM_WIN), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
      .REMAP_W(UNIT_W), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .low_q(low_q), .high_q(high_q), .remap_q(remap_q)
   );

   pciwin_calc #(
      .NUM_WIN(NUM_WIN), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
      .UNIT_W(UNIT_W), .LEN_W(LEN_W)
   ) u_calc (
      .low_q(low_q), .high_q(high_q),
      .win_valid(win_valid), .win_start(win_start), .win_len(win_len)
   );

   pciwin_match #(
      .NUM_WIN(NUM_WIN), .CPU_AW(CPU_AW), .GRAN_LG(GRAN_LG),
      .UNIT_W(UNIT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
   ) u_match (
      .cpu_addr(cpu_addr), .win_valid(win_valid), .win_start(win_start),
      .win_len(win_len), .remap_q(remap_q),
      .hit(hit), .hit_idx(hit_idx), .pci_addr(pci_addr)
   );

endmodule

// File: rtl/pciwin_decoder_chk.sv
module pciwin_decoder_chk #(
   parameter int NUM_WIN = 6,
   parameter int CPU_AW  = 32,
   parameter int GRAN_LG = 21,
   parameter int HIGH_W  = 7,
   parameter int REG_AW  = 12,
   localparam int UNIT_W = CPU_AW - GRAN_LG,
   localparam int LEN_W  = HIGH_W + 1,
   localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic                      rd_en,
   input logic [REG_AW-1:0]         addr,
   input logic [31:0]               wdata,
   input logic [31:0]               rdata,
   input logic [CPU_AW-1:0]         cpu_addr,
   input logic                      hit,
   input logic [IDX_W-1:0]          hit_idx,
   input logic [CPU_AW-1:0]         pci_addr,
   input logic [NUM_WIN-1:0]        win_valid,
   input logic [NUM_WIN*UNIT_W-1:0] win_start,
   input logic [NUM_WIN*LEN_W-1:0]  win_len,
   input logic [NUM_WIN*UNIT_W-1:0] remap_q
);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
      localparam logic [REG_AW-3:0] LOW_WORD = (REG_AW-2)'(i * 4);

      // R2
      low_loads_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr[REG_AW-1:2] == LOW_WORD)
         |=> remap_q[i*UNIT_W +: UNIT_W] == $past(wdata[UNIT_W-1:0]));

      // R5
      len_matches_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (win_len[i*LEN_W +: LEN_W] != '0) == win_valid[i]);
   end

   // R7
   hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> win_valid[hit_idx]);

   // R7
   hit_above_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> cpu_addr[CPU_AW-1:GRAN_LG] >= win_start[hit_idx*UNIT_W +: UNIT_W]);

   // R8
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> pci_addr == '0);

   // R8
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> pci_addr[GRAN_LG-1:0] == cpu_addr[GRAN_LG-1:0]);

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

bind pciwin_decoder pciwin_decoder_chk #(
   .NUM_WIN(NUM_WIN), .CPU_AW(CPU_AW), .GRAN_LG(GRAN_LG),
   .HIGH_W(HIGH_W), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
   .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_addr(cpu_addr),
   .hit(hit), .hit_idx(hit_idx), .pci_addr(pci_addr),
   .win_valid(win_valid), .win_start(win_start), .win_len(win_len),
   .remap_q(remap_q)
);

// File: tb/pciwin_decoder_bench.sv
module pciwin_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] cpu_addr = '0;
   logic        hit;
   logic [2:0]  hit_idx;
   logic [31:0] pci_addr;
   logic [5:0]  win_valid;
   logic [65:0] win_start;
   logic [47:0] win_len;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   pciwin_decoder u_pciwin_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_addr(cpu_addr),
      .hit(hit), .hit_idx(hit_idx), .pci_addr(pci_addr),
      .win_valid(win_valid), .win_start(win_start), .win_len(win_len)
   );

   // Hit table against the reset layout (R6, R7, R8)
   localparam int NV = 10;
   localparam logic [31:0] V_CPU [NV] = '{
      32'h1000_1234, 32'h11FF_FFFF, 32'h1200_0000, 32'h1400_0000, 32'hF200_0004,
      32'h2000_0000, 32'h2200_0000, 32'h25E0_0000, 32'h2600_0000, 32'h0000_0000};
   localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam int   V_IDX [NV] = '{0, 0, 1, 0, 2, 3, 4, 5, 0, 0};

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic probe(input string req, input logic [31:0] cpu,
                        input logic exp_hit, input int exp_idx, input logic [31:0] exp_pci);
      cpu_addr = cpu;
      #1;
      check(req, "hit", 32'(hit), 32'(exp_hit));
      if (exp_hit) check(req, "hit_idx", 32'(hit_idx), 32'(exp_idx));
      check(req, "pci_addr", pci_addr, exp_pci);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 reset state
      check("R6", "rdata after reset", rdata, 32'h0);
      check("R6", "valid flags", 32'(win_valid), 32'h3F);
      check("R6", "start w5", 32'(win_start[5*11 +: 11]), 32'h120);
      check("R6", "len w5", 32'(win_len[5*8 +: 8]), 32'd16);
      check("R6", "start w2", 32'(win_start[2*11 +: 11]), 32'h790);
      reg_read(12'h020, rd); check("R6", "w2 low", rd, 32'h790);
      reg_read(12'h054, rd); check("R6", "w5 high", rd, 32'h2F);
      reg_read(12'h048, rd); check("R6", "w4 remap", rd, 32'h110);

      // Table walk: R7 range and R8 identity translation at reset
      for (int v = 0; v < NV; v++)
         probe("R7", V_CPU[v], V_HIT[v], V_IDX[v], V_HIT[v] ? V_CPU[v] : 32'h0);

      // R9 rdata holds without a read
      reg_read(12'h010, rd);
      @(negedge clk);
      check("R9", "rdata hold", rdata, 32'h090);

      // R3 high mask; R5 length follows
      reg_write(12'h014, 32'hFFFF_FFFF);
      reg_read(12'h014, rd); check("R3", "high mask", rd, 32'h7F);
      check("R5", "len w1 wide", 32'(win_len[1*8 +: 8]), 32'h70);
      reg_write(12'h014, 32'h1F);

      // R3 remap mask; R8 translation and modular wrap
      reg_write(12'h018, 32'hFFFF_F300);
      reg_read(12'h018, rd); check("R3", "remap mask", rd, 32'h300);
      probe("R8", 32'h1220_0ABC, 1'b1, 1, 32'h6020_0ABC);
      reg_write(12'h018, 32'h7FF);
      probe("R8", 32'h1240_0010, 1'b1, 1, 32'h0020_0010);

      // R2 low write masks and loads remap
      reg_write(12'h000, 32'hFFFF_C881);
      reg_read(12'h000, rd); check("R2", "low mask", rd, 32'h4881);
      reg_read(12'h008, rd); check("R2", "paired remap", rd, 32'h081);
      check("R5", "start w0", 32'(win_start[0 +: 11]), 32'h081);
      check("R5", "len w0", 32'(win_len[0 +: 8]), 32'd15);

      // R4 boundary: high == low[6:0] valid, one below invalid
      reg_write(12'h004, 32'h01);
      check("R4", "equal valid", 32'(win_valid[0]), 32'h1);
      check("R5", "equal len", 32'(win_len[0 +: 8]), 32'd1);
      reg_write(12'h004, 32'h00);
      check("R4", "below invalid", 32'(win_valid[0]), 32'h0);
      check("R5", "invalid len", 32'(win_len[0 +: 8]), 32'd0);
      probe("R4", 32'h1020_0000, 1'b0, 0, 32'h0);

      // R7 overlap priority
      reg_write(12'h000, 32'h080);
      reg_write(12'h004, 32'h0F);
      reg_write(12'h030, 32'h080);
      reg_write(12'h008, 32'h200);
      probe("R7", 32'h1000_0010, 1'b1, 0, 32'h4000_0010);
      reg_write(12'h000, 32'h0FF);
      probe("R7", 32'h1000_0010, 1'b1, 3, 32'h1000_0010);

      // R1 unmapped words
      reg_write(12'h00C, 32'hFFFF_FFFF);
      reg_read(12'h00C, rd); check("R1", "gap word", rd, 32'h0);
      reg_write(12'h0FC, 32'hFFFF_FFFF);
      reg_read(12'h0FC, rd); check("R1", "beyond windows", rd, 32'h0);
      check("R1", "valid flags intact", 32'(win_valid), 32'h3E);
      reg_read(12'h058, rd); check("R1", "w5 remap intact", rd, 32'h120);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule